// File: doc/BRIEF.md
# Linked-List Directory Home Controller

This block is the memory-home side of a directory coherence scheme in which sharers are chained in a distributed linked list. For each line, the home keeps only two things: a three-valued line state and the id of the node at the head of the list. Forward and backward list pointers live in the caches, not here.

Remote nodes send read, write-ownership and write-back requests, one per cycle. The home decides each request from its local entry alone and updates that entry. One cycle later it answers with one of these: data, data together with the old head, the old head alone, a plain grant, or a retry. A new requester always becomes the head and then contacts the old head itself, so the home never sends invalidations and never buffers requests. Requests that race for one line are ordered by the cycle in which the home accepts them. Each later requester is given the earlier one as its old head, so any waiting is queued in list order inside the caches.

A small combinational model of a list entry is also exposed. It gives the state an old head takes when a new head attaches in front of it.

Top module: `dirhome_top`

## Requirements
- R1: After reset every line is in state HOME with head 0, and no response is issued until a request arrives.
- R2: A read on a HOME line answers DATA (kind 0) with final state ONLY_FRESH (1), sets head to the requester and moves the line to FRESH.
- R3: A read on a FRESH line answers DATA_PTR (kind 1) carrying the old head, with final state HEAD_FRESH (2). The requester becomes head and the line stays FRESH.
- R4: A read on a GONE line answers PTR (kind 2) carrying the old head and no data, with final state HEAD_DIRTY (5). The requester becomes head and the line stays GONE.
- R5: A write (op 1) always leaves the line GONE with the requester as head. The answer depends on the line:
  - on a HOME line it is DATA with final state ONLY_DIRTY (6);
  - if the requester is already head, it is GRANT (kind 4) with final state HEAD_DIRTY;
  - otherwise it is DATA_PTR (line FRESH) or PTR (line GONE) carrying the old head, with final state HEAD_DIRTY.
- R6: A write-back (op 2) from the recorded head of a non-HOME line answers GRANT with final state INVALID (0). If a next node is supplied, it becomes head and the state is kept. If not, the line returns to HOME.
- R7: A write-back from a node that is not the recorded head, or one on a HOME line, answers RETRY (kind 3) and changes nothing. The reserved op 3 is also answered with RETRY and changes nothing.
- R8: The attach model moves an old head as follows, and flags each of these moves as valid:
  - HEAD_FRESH (2) goes to MID_VALID (3);
  - ONLY_FRESH (1) goes to TAIL_VALID (4);
  - HEAD_DIRTY (5) goes to MID_VALID;
  - ONLY_DIRTY (6) goes to TAIL_VALID.
  Any other input state, or an attach request that is not valid, passes through unchanged and is not flagged.
- R9: Back-to-back requests to one line are served in arrival order. Each one sees the previous requester as its old head.
- R10: Every accepted request gets exactly one response, one clock later. The response node field is 0 unless the kind is DATA_PTR or PTR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 2 | 0 read, 1 write, 2 write-back, 3 reserved |
| req_line_i | input | LINE_W | Line index |
| req_node_i | input | NODE_W | Requesting node id |
| req_next_valid_i | input | 1 | Write-back supplies a next node |
| req_next_node_i | input | NODE_W | Next node that becomes head on write-back |
| rsp_valid_o | output | 1 | Response present |
| rsp_kind_o | output | 3 | 0 DATA, 1 DATA_PTR, 2 PTR, 3 RETRY, 4 GRANT |
| rsp_node_o | output | NODE_W | Old head id for DATA_PTR and PTR, else 0 |
| rsp_final_o | output | 4 | List state the requester ends in |
| att_valid_i | input | 1 | Attach query valid |
| att_state_i | input | 4 | Current list state of the old head |
| att_state_o | output | 4 | List state after the attach |
| att_ok_o | output | 1 | Attach transition recognised |

## Verification
The bench uses the default 16 lines and 6-bit node ids. With 16 lines, every line can be driven to each of its three states, and lines can be interleaved so that one line's state cannot leak into another. With 6-bit ids, the pseudo-random phase can use node ids up to 63, including 0, which is also the reset head. It can therefore produce matching and mismatching write-back heads and long chains of read attaches. Directed sequences walk a single line through every HOME/FRESH/GONE transition. A table sweep covers every attach input.

// File: rtl/dirhome_pkg.sv
package dirhome_pkg;

  typedef enum logic [1:0] {
    H_HOME  = 2'd0,
    H_FRESH = 2'd1,
    H_GONE  = 2'd2
  } home_st_e;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_WBACK = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    RSP_DATA     = 3'd0,
    RSP_DATA_PTR = 3'd1,
    RSP_PTR      = 3'd2,
    RSP_RETRY    = 3'd3,
    RSP_GRANT    = 3'd4
  } rsp_e;

  typedef enum logic [3:0] {
    LS_INVALID    = 4'd0,
    LS_ONLY_FRESH = 4'd1,
    LS_HEAD_FRESH = 4'd2,
    LS_MID_VALID  = 4'd3,
    LS_TAIL_VALID = 4'd4,
    LS_HEAD_DIRTY = 4'd5,
    LS_ONLY_DIRTY = 4'd6,
    LS_PENDING    = 4'd7
  } list_st_e;

endpackage

// File: rtl/dirhome_rst_sync.sv
module dirhome_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/dirhome_store.sv
module dirhome_store
  import dirhome_pkg::*;
#(
  parameter int NLINES = 16,
  parameter int NODE_W = 6,
  localparam int LINE_W = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] rd_line_i,
  output home_st_e          rd_state_o,
  output logic [NODE_W-1:0] rd_head_o,
  input  logic              wr_en_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  home_st_e          wr_state_i,
  input  logic [NODE_W-1:0] wr_head_i
);
  home_st_e          st_q [NLINES];
  logic [NODE_W-1:0] hd_q [NLINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) begin
        st_q[i] <= H_HOME;
        hd_q[i] <= '0;
      end
    end else if (wr_en_i) begin
      st_q[wr_line_i] <= wr_state_i;
      hd_q[wr_line_i] <= wr_head_i;
    end
  end

  assign rd_state_o = st_q[rd_line_i];
  assign rd_head_o  = hd_q[rd_line_i];
endmodule

// File: rtl/dirhome_decide.sv
module dirhome_decide
  import dirhome_pkg::*;
#(
  parameter int NODE_W = 6
) (
  input  op_e               op_i,
  input  logic [NODE_W-1:0] node_i,
  input  logic              next_valid_i,
  input  logic [NODE_W-1:0] next_node_i,
  input  home_st_e          cur_state_i,
  input  logic [NODE_W-1:0] cur_head_i,
  output logic              wr_o,
  output home_st_e          nxt_state_o,
  output logic [NODE_W-1:0] nxt_head_o,
  output rsp_e              kind_o,
  output logic [NODE_W-1:0] rnode_o,
  output list_st_e          final_o
);
  logic is_head;
  assign is_head = (cur_head_i == node_i);

  always_comb begin
    wr_o        = 1'b0;
    nxt_state_o = cur_state_i;
    nxt_head_o  = cur_head_i;
    kind_o      = RSP_RETRY;
    rnode_o     = '0;
    final_o     = LS_INVALID;
    unique case (op_i)
      OP_READ: begin
        wr_o       = 1'b1;
        nxt_head_o = node_i;
        unique case (cur_state_i)
          H_HOME: begin
            kind_o      = RSP_DATA;
            nxt_state_o = H_FRESH;
            final_o     = LS_ONLY_FRESH;
          end
          H_FRESH: begin
            kind_o  = RSP_DATA_PTR;
            rnode_o = cur_head_i;
            final_o = LS_HEAD_FRESH;
          end
          default: begin
            kind_o  = RSP_PTR;
            rnode_o = cur_head_i;
            final_o = LS_HEAD_DIRTY;
          end
        endcase
      end
      OP_WRITE: begin
        wr_o        = 1'b1;
        nxt_state_o = H_GONE;
        nxt_head_o  = node_i;
        final_o     = LS_HEAD_DIRTY;
        if (cur_state_i == H_HOME) begin
          kind_o  = RSP_DATA;
          final_o = LS_ONLY_DIRTY;
        end else if (is_head) begin
          kind_o = RSP_GRANT;
        end else if (cur_state_i == H_FRESH) begin
          kind_o  = RSP_DATA_PTR;
          rnode_o = cur_head_i;
        end else begin
          kind_o  = RSP_PTR;
          rnode_o = cur_head_i;
        end
      end
      OP_WBACK: begin
        if (cur_state_i != H_HOME && is_head) begin
          wr_o   = 1'b1;
          kind_o = RSP_GRANT;
          if (next_valid_i) begin
            nxt_head_o = next_node_i;
          end else begin
            nxt_state_o = H_HOME;
            nxt_head_o  = '0;
          end
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dirhome_attach.sv
module dirhome_attach
  import dirhome_pkg::*;
(
  input  logic     valid_i,
  input  list_st_e state_i,
  output list_st_e state_o,
  output logic     ok_o
);
  always_comb begin
    state_o = state_i;
    ok_o    = 1'b0;
    if (valid_i) begin
      unique case (state_i)
        LS_HEAD_FRESH, LS_HEAD_DIRTY: begin
          state_o = LS_MID_VALID;
          ok_o    = 1'b1;
        end
        LS_ONLY_FRESH, LS_ONLY_DIRTY: begin
          state_o = LS_TAIL_VALID;
          ok_o    = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dirhome_top.sv
module dirhome_top
  import dirhome_pkg::*;
#(
  parameter int NLINES = 16,
  parameter int NODE_W = 6,
  localparam int LINE_W = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [LINE_W-1:0] req_line_i,
  input  logic [NODE_W-1:0] req_node_i,
  input  logic              req_next_valid_i,
  input  logic [NODE_W-1:0] req_next_node_i,
  output logic              rsp_valid_o,
  output logic [2:0]        rsp_kind_o,
  output logic [NODE_W-1:0] rsp_node_o,
  output logic [3:0]        rsp_final_o,
  input  logic              att_valid_i,
  input  logic [3:0]        att_state_i,
  output logic [3:0]        att_state_o,
  output logic              att_ok_o
);
  logic              rst_sn;
  home_st_e          cur_state, nxt_state;
  logic [NODE_W-1:0] cur_head, nxt_head, dec_node;
  logic              dec_wr;
  rsp_e              dec_kind;
  list_st_e          dec_final, att_out;

  logic              rsp_valid_q, rsp_valid_d;
  logic [2:0]        rsp_kind_q, rsp_kind_d;
  logic [NODE_W-1:0] rsp_node_q, rsp_node_d;
  logic [3:0]        rsp_final_q, rsp_final_d;

  dirhome_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sn)
  );

  dirhome_store #(.NLINES(NLINES), .NODE_W(NODE_W)) u_store (
    .clk(clk), .rst_n(rst_sn),
    .rd_line_i(req_line_i), .rd_state_o(cur_state), .rd_head_o(cur_head),
    .wr_en_i(req_valid_i && dec_wr), .wr_line_i(req_line_i),
    .wr_state_i(nxt_state), .wr_head_i(nxt_head)
  );

  dirhome_decide #(.NODE_W(NODE_W)) u_decide (
    .op_i(op_e'(req_op_i)), .node_i(req_node_i),
    .next_valid_i(req_next_valid_i), .next_node_i(req_next_node_i),
    .cur_state_i(cur_state), .cur_head_i(cur_head),
    .wr_o(dec_wr), .nxt_state_o(nxt_state), .nxt_head_o(nxt_head),
    .kind_o(dec_kind), .rnode_o(dec_node), .final_o(dec_final)
  );

  dirhome_attach u_attach (
    .valid_i(att_valid_i), .state_i(list_st_e'(att_state_i)),
    .state_o(att_out), .ok_o(att_ok_o)
  );
  assign att_state_o = att_out;

  // next-state for the response register
  always_comb begin
    rsp_valid_d = req_valid_i;
    rsp_kind_d  = rsp_kind_q;
    rsp_node_d  = rsp_node_q;
    rsp_final_d = rsp_final_q;
    if (req_valid_i) begin
      rsp_kind_d  = dec_kind;
      rsp_node_d  = dec_node;
      rsp_final_d = dec_final;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rsp_valid_q <= 1'b0;
      rsp_kind_q  <= '0;
      rsp_node_q  <= '0;
      rsp_final_q <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_kind_q  <= rsp_kind_d;
      rsp_node_q  <= rsp_node_d;
      rsp_final_q <= rsp_final_d;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_kind_o  = rsp_kind_q;
  assign rsp_node_o  = rsp_node_q;
  assign rsp_final_o = rsp_final_q;

  // R10: one response per request, one cycle later
  p_rsp_follows_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    req_valid_i |=> rsp_valid_o);
  p_rsp_quiet_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    !req_valid_i |=> !rsp_valid_o);
  // R7: only write-back or the reserved op may be refused
  p_retry_only_wback_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_valid_i && req_op_i != 2'd2 && req_op_i != 2'd3) |=> rsp_kind_o != 3'd3);
  // R4: pointer-only answer means the requester ends dirty
  p_ptr_dirty_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (rsp_valid_o && rsp_kind_o == 3'd2) |-> rsp_final_o == 4'd5);
  // R8: a recognised attach lands in the middle or at the tail
  p_attach_mid_tail_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    att_ok_o |-> (att_state_o == 4'd3 || att_state_o == 4'd4));
  p_attach_only_tail_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (att_valid_i && (att_state_i == 4'd1 || att_state_i == 4'd6)) |-> att_state_o == 4'd4);
endmodule

// File: tb/dirhome_top_tb_top.sv
module dirhome_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [1:0] req_op;
  logic [3:0] req_line;
  logic [5:0] req_node;
  logic       req_nv;
  logic [5:0] req_nn;
  logic       rsp_valid;
  logic [2:0] rsp_kind;
  logic [5:0] rsp_node;
  logic [3:0] rsp_final;
  logic       att_valid;
  logic [3:0] att_in, att_out;
  logic       att_ok;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  int rs [16];
  int rh [16];

  always #4 clk = ~clk;

  dirhome_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_line_i(req_line),
    .req_node_i(req_node), .req_next_valid_i(req_nv), .req_next_node_i(req_nn),
    .rsp_valid_o(rsp_valid), .rsp_kind_o(rsp_kind), .rsp_node_o(rsp_node),
    .rsp_final_o(rsp_final),
    .att_valid_i(att_valid), .att_state_i(att_in), .att_state_o(att_out), .att_ok_o(att_ok)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural home model: 0 HOME 1 FRESH 2 GONE
  task automatic step(input bit v, input int op, input int line, input int node,
                      input bit nv, input int nn, input string req);
    int ek, en, ef;
    req_valid = v; req_op = 2'(op); req_line = 4'(line);
    req_node = 6'(node); req_nv = nv; req_nn = 6'(nn);
    ek = 3; en = 0; ef = 0;
    if (v) begin
      if (op == 0) begin
        if (rs[line] == 0) begin ek = 0; ef = 1; rs[line] = 1; end
        else if (rs[line] == 1) begin ek = 1; en = rh[line]; ef = 2; end
        else begin ek = 2; en = rh[line]; ef = 5; end
        rh[line] = node;
      end else if (op == 1) begin
        ef = 5;
        if (rs[line] == 0) begin ek = 0; ef = 6; end
        else if (rh[line] == node) ek = 4;
        else if (rs[line] == 1) begin ek = 1; en = rh[line]; end
        else begin ek = 2; en = rh[line]; end
        rs[line] = 2; rh[line] = node;
      end else if (op == 2) begin
        if (rs[line] != 0 && rh[line] == node) begin
          ek = 4;
          if (nv) rh[line] = nn;
          else begin rs[line] = 0; rh[line] = 0; end
        end
      end
    end
    @(negedge clk);
    check({req, " valid"}, int'(rsp_valid), int'(v));
    if (v) begin
      check({req, " kind"},  int'(rsp_kind),  ek);
      check({req, " node"},  int'(rsp_node),  en);
      check({req, " final"}, int'(rsp_final), ef);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    rst_n = 1'b0; req_valid = 0; req_op = 0; req_line = 0; req_node = 0;
    req_nv = 0; req_nn = 0; att_valid = 0; att_in = 0;
    for (int i = 0; i < 16; i++) begin rs[i] = 0; rh[i] = 0; end
    repeat (3) @(negedge clk);
    check("R1 rsp idle in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 rsp idle after reset", int'(rsp_valid), 0);

    // one line through every state
    step(1, 0, 1, 5,  0, 0, "R1 R2 read HOME");
    step(1, 0, 1, 9,  0, 0, "R3 read FRESH");
    step(1, 0, 1, 12, 0, 0, "R9 R3 chained read");
    step(1, 1, 1, 12, 0, 0, "R5 write by head FRESH");
    step(1, 0, 1, 3,  0, 0, "R4 read GONE");
    step(1, 0, 1, 7,  0, 0, "R9 R4 chained read GONE");
    step(1, 2, 1, 12, 0, 0, "R7 wback non-head");
    step(0, 0, 1, 0,  0, 0, "R10 idle");
    step(1, 2, 1, 7,  1, 3, "R6 wback head with next");
    step(1, 0, 1, 20, 0, 0, "R6 head now next node");
    step(1, 2, 1, 20, 0, 0, "R6 wback last");
    step(1, 0, 1, 1,  0, 0, "R6 line back to HOME");
    // writes
    step(1, 1, 2, 4, 0, 0, "R5 write HOME");
    step(1, 1, 2, 4, 0, 0, "R5 write head GONE");
    step(1, 1, 2, 8, 0, 0, "R5 write non-head GONE");
    step(1, 0, 3, 2, 0, 0, "R2 read line3");
    step(1, 1, 3, 6, 0, 0, "R5 write non-head FRESH");
    step(1, 2, 5, 0, 0, 0, "R7 wback on HOME");
    step(1, 0, 5, 0, 0, 0, "R7 line5 still HOME");
    step(1, 3, 5, 0, 0, 0, "R7 reserved op");
    step(1, 0, 5, 11, 0, 0, "R7 line5 untouched by reserved");
    // interleaved lines stay separate
    step(1, 0, 0, 33, 0, 0, "R2 read line0");
    step(1, 0, 15, 34, 0, 0, "R2 read line15");
    step(1, 0, 0, 35, 0, 0, "R3 line0 own head");

    // pseudo-random stream over lines 8..15
    seed = 32'h1234_5678;
    for (int k = 0; k < 600; k++) begin
      int op, line, node;
      seed = seed * 32'd1103515245 + 32'd12345;
      op   = int'(seed[17:16]);
      line = 8 + int'(seed[20:18]);
      node = int'(seed[26:21]);
      if (op == 2 && seed[27]) node = rh[line];
      step(seed[30] | seed[29], op, line, node, seed[28], int'(seed[13:8]),
           "R9 R10 random stream");
    end
    step(0, 0, 0, 0, 0, 0, "R10 drain");

    // attach table
    for (int s = 0; s < 8; s++) begin
      int es, eo;
      att_valid = 1'b1; att_in = 4'(s);
      eo = 1; es = s;
      if (s == 2 || s == 5) es = 3;
      else if (s == 1 || s == 6) es = 4;
      else eo = 0;
      @(negedge clk);
      check("R8 attach state", int'(att_out), es);
      check("R8 attach ok", int'(att_ok), eo);
    end
    att_valid = 1'b0; att_in = 4'd2;
    @(negedge clk);
    check("R8 attach invalid passthrough", int'(att_out), 2);
    check("R8 attach invalid ok", int'(att_ok), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule